// File: doc/BRIEF.md
# Windowed Integer Register File

This block is a register file in which every procedure gets its own frame of registers. Software always addresses 32 architectural registers in four groups of eight. A call command moves the window pointer forward one frame, and a return command moves it back. Moving the pointer renames registers instead of copying them. Neighbouring frames overlap, so the values a caller leaves in its outgoing group appear in the callee's incoming group with no data movement.

The physical array holds a fixed number of resident frames. A call made when every on-chip frame is in use first writes the oldest frame out to a memory stack. A return made when only the current frame is resident first reads the caller's frame back in. During such a transfer the block raises a busy flag. It then moves sixteen words, one at a time, over a simple request/acknowledge port. The block has two combinational read ports and one write port that takes effect on the clock edge.

Top module: `regwin_file`

## Requirements
- R1: After reset, busy and mem_req are low and all 32 architectural registers read zero.
- R2: Register indices 0–7 are globals. The same storage is visible in every window, and calls and returns leave it unchanged.
- R3: On a call, the caller's outgoing registers (indices 8–15) appear at the new frame's incoming registers (indices 24–31), and the new frame's locals (indices 16–23) read zero.
- R4: On a return with the caller still resident, the current incoming registers appear again at the caller's outgoing registers, and the caller's locals and incoming registers hold the values they had before the call.
- R5: Both read ports are combinational. A write in the same cycle to the register being read is forwarded to that read port, and the write is stored at the clock edge.
- R6: With NWIN = 4, a call chain that never has more than 4 frames resident makes no memory request. Writes to memory occur only while all 4 frames are resident.
- R7: A call made with 4 frames resident first spills the oldest frame. This is 16 write requests to consecutive addresses sp, sp+1 … sp+15: that frame's locals 0–7 first, then its incoming registers 0–7. The memory stack pointer then advances by 16, and busy is high throughout.
- R8: A return made with 1 frame resident and a stack pointer of at least 16 first fills the caller's frame. This is 16 read requests at sp−16 … sp−1, in the same word order as a spill. The pointer then drops by 16, and the caller's locals and incoming registers read back the values they held before they were spilled.
- R9: Once raised, a memory request keeps its address, write flag and write data unchanged until it is acknowledged.
- R10: One call or return that arrives while busy is held and executed after the transfer. Any further command that arrives while busy and a command is already held is dropped.
- R11: A return with only the current frame resident and a stack pointer of zero is ignored: no memory request is made and no register changes.
- R12: A write issued in the same cycle as a call uses the window mapping in effect before the call. A write to index 8 in that cycle is therefore read at index 24 after the call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_save | input | 1 | Call: advance the window one frame |
| cmd_restore | input | 1 | Return: move the window back one frame |
| busy | output | 1 | A transfer is in progress or a command is held |
| rd_addr_a | input | 5 | Read port A register index |
| rd_data_a | output | DW | Read port A data |
| rd_addr_b | input | 5 | Read port B register index |
| rd_data_b | output | DW | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register index |
| wr_data | input | DW | Write data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for a spill write, 0 for a fill read |
| mem_addr | output | MAW | Memory word address |
| mem_wdata | output | DW | Spill write data |
| mem_rdata | input | DW | Fill read data |
| mem_ack | input | 1 | Memory acknowledge for the current word |

## Verification
A wrong window pointer shows up at the read ports in the first cycle after the faulty call or return: incoming, local or outgoing values come from the wrong frame. A wrong resident-frame count or stack pointer stays hidden until the next overflow or underflow. At that point it shows as a transfer that is missing or not expected, as wrong spill addresses, or as corrupted locals one to four returns later, when the filled frame becomes visible. The bench therefore runs a call chain deep enough to spill several times and unwinds it completely, checking every frame's registers and every transfer word.

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int DW   = 32,
  parameter int NWIN = 4,
  parameter int MAW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_save,
  input  logic           cmd_restore,
  output logic           busy,
  input  logic [4:0]     rd_addr_a,
  output logic [DW-1:0]  rd_data_a,
  input  logic [4:0]     rd_addr_b,
  output logic [DW-1:0]  rd_data_b,
  input  logic           wr_en,
  input  logic [4:0]     wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic           mem_req,
  output logic           mem_we,
  output logic [MAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack
);
  localparam int S    = NWIN + 1;
  localparam int SW   = $clog2(S);
  localparam int FW   = 16;
  localparam int XCW  = $clog2(FW);
  localparam int PHYS = 8 + FW * S;
  localparam int PW   = $clog2(PHYS);
  localparam int RW   = $clog2(NWIN + 1);

  logic [DW-1:0]  rf [PHYS];
  logic [SW-1:0]  cwp;
  logic [RW-1:0]  res;
  logic [MAW-1:0] sp;
  logic           xfer, xsave, held_v, held_save;
  logic [XCW-1:0] xcnt;

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] s);
    return (s == SW'(S-1)) ? '0 : s + 1'b1;
  endfunction

  function automatic logic [SW-1:0] prv(input logic [SW-1:0] s);
    return (s == '0) ? SW'(S-1) : s - 1'b1;
  endfunction

  function automatic logic [PW-1:0] phys_idx(input logic [4:0] r, input logic [SW-1:0] w);
    int idx;
    case (r[4:3])
      2'd0:    idx = int'(r[2:0]);
      2'd1:    idx = 8 + FW * int'(nxt(w)) + 8 + int'(r[2:0]);
      2'd2:    idx = 8 + FW * int'(w) + int'(r[2:0]);
      default: idx = 8 + FW * int'(w) + 8 + int'(r[2:0]);
    endcase
    return PW'(idx);
  endfunction

  logic          in_cmd, go, eff_save, last;
  logic [SW-1:0] xslot;
  logic [PW-1:0] xidx;

  assign in_cmd   = cmd_save | cmd_restore;
  assign busy     = xfer | held_v;
  assign go       = !xfer && (held_v || in_cmd);
  assign eff_save = held_v ? held_save : cmd_save;
  assign last     = xfer && mem_ack && (xcnt == XCW'(FW-1));
  assign xslot    = xsave ? nxt(nxt(cwp)) : prv(cwp);
  assign xidx     = PW'(8 + FW * int'(xslot) + int'(xcnt));

  assign mem_req   = xfer;
  assign mem_we    = xsave;
  assign mem_wdata = rf[xidx];
  assign mem_addr  = xsave ? sp + MAW'(xcnt) : sp - MAW'(FW) + MAW'(xcnt);

  assign rd_data_a = (wr_en && wr_addr == rd_addr_a) ? wr_data : rf[phys_idx(rd_addr_a, cwp)];
  assign rd_data_b = (wr_en && wr_addr == rd_addr_b) ? wr_data : rf[phys_idx(rd_addr_b, cwp)];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PHYS; i++) rf[i] <= '0;
      cwp       <= '0;
      res       <= RW'(1);
      sp        <= '0;
      xfer      <= 1'b0;
      xsave     <= 1'b0;
      xcnt      <= '0;
      held_v    <= 1'b0;
      held_save <= 1'b0;
    end else begin
      if (wr_en) rf[phys_idx(wr_addr, cwp)] <= wr_data;

      if (xfer && !held_v && in_cmd) begin
        held_v    <= 1'b1;
        held_save <= cmd_save;
      end
      if (!xfer && held_v) held_v <= 1'b0;

      if (go) begin
        if (eff_save) begin
          if (res == RW'(NWIN)) begin
            xfer  <= 1'b1;
            xsave <= 1'b1;
            xcnt  <= '0;
          end else begin
            cwp <= nxt(cwp);
            res <= res + 1'b1;
            for (int j = 0; j < 8; j++) rf[phys_idx({2'b10, 3'(j)}, nxt(cwp))] <= '0;
          end
        end else if (res != RW'(1)) begin
          cwp <= prv(cwp);
          res <= res - 1'b1;
          for (int j = 0; j < 8; j++) rf[phys_idx({2'b10, 3'(j)}, cwp)] <= '0;
        end else if (sp != '0) begin
          xfer  <= 1'b1;
          xsave <= 1'b0;
          xcnt  <= '0;
        end
      end

      if (xfer && mem_ack) begin
        if (!xsave) rf[xidx] <= mem_rdata;
        xcnt <= xcnt + 1'b1;
        if (last) begin
          xfer <= 1'b0;
          if (xsave) begin
            sp  <= sp + MAW'(FW);
            cwp <= nxt(cwp);
            for (int j = 0; j < 8; j++) rf[phys_idx({2'b10, 3'(j)}, nxt(cwp))] <= '0;
          end else begin
            sp  <= sp - MAW'(FW);
            cwp <= prv(cwp);
            for (int j = 0; j < 8; j++) rf[phys_idx({2'b10, 3'(j)}, cwp)] <= '0;
          end
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9
  AST_SPILL_FULL: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> res == RW'(NWIN)); // R6
  AST_FILL_SRC: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_we |-> res == RW'(1) && sp >= MAW'(FW)); // R8
  AST_SP_STEP: assert property (@(posedge clk) disable iff (rst)
    sp != $past(sp) |-> (sp == $past(sp) + MAW'(FW) || sp == $past(sp) - MAW'(FW))); // R7
  AST_WIN_STEP: assert property (@(posedge clk) disable iff (rst)
    cwp != $past(cwp) |-> (cwp == nxt($past(cwp)) || cwp == prv($past(cwp)))); // R3
  AST_RES_RANGE: assert property (@(posedge clk) disable iff (rst)
    res >= RW'(1) && res <= RW'(NWIN)); // R6
endmodule

// File: tb/tb_regwin_file.sv
module tb_regwin_file;
  localparam int CLK_P = 10;
  logic clk = 0, rst = 1;
  logic cmd_save = 0, cmd_restore = 0, busy;
  logic [4:0] rd_addr_a = 0, rd_addr_b = 0, wr_addr = 0;
  logic [31:0] rd_data_a, rd_data_b, wr_data = 0;
  logic wr_en = 0;
  logic mem_req, mem_we, mem_ack = 0;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = 0;

  regwin_file dut (.clk, .rst, .cmd_save, .cmd_restore, .busy,
    .rd_addr_a, .rd_data_a, .rd_addr_b, .rd_data_b,
    .wr_en, .wr_addr, .wr_data,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errs = 0, wn = 0, rn = 0;
  bit done = 0;
  logic [31:0] bmem [256];
  logic [15:0] wlog_a [256];
  logic [31:0] wlog_d [256];
  logic [15:0] rlog_a [256];
  logic seen = 0, hw;
  logic [15:0] ha;
  logic [31:0] hd;

  always @(negedge clk) begin
    if (rst) begin mem_ack = 0; seen = 0; end
    else if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (!seen) begin seen = 1; ha = mem_addr; hd = mem_wdata; hw = mem_we; end
      else begin
        seen = 0;
        checks++;
        if (ha !== mem_addr || hw !== mem_we || (hw && hd !== mem_wdata)) begin
          errs++;
          $display("FAIL R9 request changed act=%h/%h exp=%h/%h", mem_addr, mem_wdata, ha, hd);
        end
        if (mem_we) begin
          bmem[mem_addr[7:0]] = mem_wdata;
          wlog_a[wn[7:0]] = mem_addr; wlog_d[wn[7:0]] = mem_wdata; wn++;
        end else begin
          mem_rdata = bmem[mem_addr[7:0]];
          rlog_a[rn[7:0]] = mem_addr; rn++;
        end
        mem_ack = 1;
      end
    end
  end

  function automatic logic [31:0] pat(int d, int r);
    return 32'hA000_0000 | 32'(d << 8) | 32'(r);
  endfunction
  function automatic logic [31:0] insv(int d, int j);
    return (d == 0) ? pat(0, 24 + j) : pat(d - 1, 8 + j);
  endfunction
  function automatic logic [31:0] gv(int r);
    return 32'h6000_0000 | 32'(r);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(string tag, int r, logic [31:0] exp);
    @(negedge clk);
    rd_addr_a = 5'(r); rd_addr_b = 5'(r);
    #1;
    chk(tag, rd_data_a, exp);
    chk(tag, rd_data_b, exp);
  endtask

  task automatic wr(int r, logic [31:0] v);
    @(negedge clk);
    wr_en = 1; wr_addr = 5'(r); wr_data = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cmd(bit s);
    @(negedge clk);
    cmd_save = s; cmd_restore = !s;
    @(negedge clk);
    cmd_save = 0; cmd_restore = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic chk_frame(string tag, int d);
    for (int j = 0; j < 8; j++) begin
      chk_reg(tag, 16 + j, pat(d, 16 + j));
      chk_reg(tag, 24 + j, insv(d, j));
      chk_reg(tag, 8 + j, pat(d, 8 + j));
      chk_reg("R2", j, gv(j));
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    int bres, esp, w0, r0;
    logic [31:0] x, y, z;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    for (int r = 0; r < 32; r++) chk_reg("R1", r, 0);

    for (int j = 0; j < 8; j++) begin
      wr(j, gv(j)); wr(16 + j, pat(0, 16 + j));
      wr(24 + j, pat(0, 24 + j)); wr(8 + j, pat(0, 8 + j));
    end
    bres = 1; esp = 0;

    for (int d = 0; d < 9; d++) begin
      w0 = wn; r0 = rn;
      cmd(1);
      if (bres == 4) begin
        chk("R7 count", 32'(wn - w0), 16);
        for (int i = 0; i < 16; i++) begin
          chk("R7 addr", 32'(wlog_a[8'(w0 + i)]), 32'(esp + i));
          chk("R7 data", wlog_d[8'(w0 + i)], (i < 8) ? pat(d - 3, 16 + i) : insv(d - 3, i - 8));
        end
        esp += 16;
      end else begin
        chk("R6 traffic", 32'(wn - w0 + rn - r0), 0);
        bres++;
      end
      for (int j = 0; j < 8; j++) begin
        chk_reg("R3 ins", 24 + j, pat(d, 8 + j));
        chk_reg("R3 locals", 16 + j, 0);
        chk_reg("R2", j, gv(j));
      end
      for (int j = 0; j < 8; j++) begin
        wr(16 + j, pat(d + 1, 16 + j)); wr(8 + j, pat(d + 1, 8 + j));
      end
    end

    for (int d = 9; d > 0; d--) begin
      w0 = wn; r0 = rn;
      cmd(0);
      if (bres == 1) begin
        chk("R8 count", 32'(rn - r0), 16);
        for (int i = 0; i < 16; i++)
          chk("R8 addr", 32'(rlog_a[8'(r0 + i)]), 32'(esp - 16 + i));
        esp -= 16;
        chk_frame("R8 frame", d - 1);
      end else begin
        chk("R6 traffic", 32'(wn - w0 + rn - r0), 0);
        bres--;
        chk_frame("R4 frame", d - 1);
      end
    end

    w0 = wn; r0 = rn;
    cmd(0);
    chk("R11 traffic", 32'(wn - w0 + rn - r0), 0);
    chk_frame("R11 frame", 0);

    x = 32'hC0DE_0020;
    @(negedge clk);
    wr_en = 1; wr_addr = 5'd20; wr_data = x; rd_addr_a = 5'd20; rd_addr_b = 5'd3;
    #1;
    chk("R5 forward", rd_data_a, x);
    chk("R5 other port", rd_data_b, gv(3));
    @(negedge clk);
    wr_en = 0;
    chk_reg("R5 stored", 20, x);

    y = 32'hBEEF_0008;
    @(negedge clk);
    cmd_save = 1; wr_en = 1; wr_addr = 5'd8; wr_data = y;
    @(negedge clk);
    cmd_save = 0; wr_en = 0;
    chk_reg("R12 ins0", 24, y);
    chk_reg("R12 ins1", 25, pat(0, 9));

    cmd(1); cmd(1);
    z = 32'h1234_5678;
    wr(16, z);
    w0 = wn;
    @(negedge clk);
    cmd_save = 1;
    @(negedge clk);
    cmd_save = 0; cmd_restore = 1;
    chk("R7 busy", 32'(busy), 1);
    @(negedge clk);
    cmd_restore = 0; cmd_save = 1;
    @(negedge clk);
    cmd_save = 0;
    while (busy) @(negedge clk);
    chk("R10 spill", 32'(wn - w0), 16);
    chk_reg("R10 local kept", 16, z);
    chk_reg("R10 local zero", 17, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule